// File: doc/BRIEF.md
# Replay FIFO with Half-Level Flag

A single-clock first-in/first-out buffer for 9-bit words, sized by a power-of-two depth parameter (512 words unless overridden). The ninth bit lets a parity or control bit travel with each byte. Producers pulse a write enable and consumers pulse a read enable. Each enable is a one-cycle strobe sampled on the rising clock edge. Three active-low status outputs report an empty buffer, a full buffer, and a buffer holding more than half its depth.

A rewind strobe moves the read side back to the first location while the write side keeps its position. Everything written since reset can then be read a second time, provided fewer than DEPTH words have been written since reset. A write into a full buffer is dropped. So is a read from an empty buffer, and so is any strobe that comes in the same cycle as a rewind.

Occupancy is tracked by a four-state machine:
- `OCC_EMPTY` means nothing is stored.
- `OCC_LOW` means 1 to DEPTH/2 words are stored.
- `OCC_HIGH` means DEPTH/2+1 to DEPTH-1 words are stored.
- `OCC_FULL` means DEPTH words are stored.

Its named transitions are:
- FILL: `OCC_EMPTY` to `OCC_LOW`/`OCC_HIGH` on a net write.
- CROSS_UP: `OCC_LOW` to `OCC_HIGH` on a net write.
- TOP: `OCC_HIGH` to `OCC_FULL` on a net write.
- LEAVE_TOP: `OCC_FULL` to `OCC_HIGH`/`OCC_LOW` on a net read.
- CROSS_DOWN: `OCC_HIGH` to `OCC_LOW` on a net read.
- DRAIN: `OCC_LOW` to `OCC_EMPTY` on a net read.
- REWIND: from any state to the level given by the write position.

The flags come from the state register, so they change one clock after the strobe that moves them. DEPTH must be at least 4.

Top module: `replay_fifo`

## Requirements
- R1: After reset, empty_n = 0, full_n = 1, half_n = 1 and rd_valid = 0. Both positions are at location zero.
- R2: Words come out in the order they were accepted, with all 9 bits intact, bit 8 included.
- R3: A write while full_n = 0 is dropped: stored contents and write position are unchanged.
- R4: A read while empty_n = 0 is dropped: rd_valid stays 0 and rd_data keeps its previous value.
- R5: In the cycle after a clock edge, empty_n is 0 exactly when the stored count is zero.
- R6: full_n is 0 exactly when DEPTH words are stored. DEPTH writes after reset with no reads drive it low.
- R7: half_n goes low on the write that takes the count above DEPTH/2. It goes high again on the read that brings the count back to DEPTH/2 or fewer.
- R8: A rewind (rt_en = 1) sets the read position to location zero and leaves the write position alone. All flags are re-derived from the new count, which equals the number of words written since reset. Subsequent reads replay from the first word written since reset.
- R9: A read or write strobe in the same cycle as rt_en is ignored: no data is stored, no word is read, and rd_valid stays 0.
- R10: A read and a write in the same cycle are both accepted when their flags allow, and the count is unchanged. When the buffer is full, only the read is accepted.
- R11: rd_data is registered and holds the last word read. rd_valid pulses high for one cycle after each accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read strobe |
| rt_en | input | 1 | Rewind strobe (read position to zero) |
| rd_data | output | 9 | Last word read |
| rd_valid | output | 1 | One-cycle pulse after an accepted read |
| empty_n | output | 1 | Low when nothing is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a read and a write together. The bench provokes this at mid-level and again at exactly full, where the read must succeed and the write must be dropped. A long mixed sweep also hits the pair often on an 8-deep instance.

The second pair is a rewind with read and write strobes. The bench raises all three at once and then reads the buffer dry. It judges the result by the replayed words, by rd_valid staying low, and by the buffer reporting empty exactly after the pre-rewind words.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_LOW   = 2'd1,
        OCC_HIGH  = 2'd2,
        OCC_FULL  = 2'd3
    } occ_e;

endpackage

// File: rtl/rf_ptr_ctl.sv
module rf_ptr_ctl #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          rt_en,
    input  logic          empty_n,
    input  logic          full_n,
    output logic          wr_acc,
    output logic          rd_acc,
    output logic          rewind,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [PW-1:0] cnt_next
);

    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_step;
    logic [PW-1:0] rd_step;

    // Strobes are only honoured in a cycle without a rewind.
    always_comb begin
        rewind  = rt_en;
        wr_acc  = !rt_en && wr_en && full_n;
        rd_acc  = !rt_en && rd_en && empty_n;
        wr_step = {{(PW-1){1'b0}}, wr_acc};
        rd_step = {{(PW-1){1'b0}}, rd_acc};
        if (rt_en)
            cnt_next = wr_ptr;
        else
            cnt_next = (wr_ptr + wr_step) - (rd_ptr + rd_step);
        wr_addr = wr_ptr[AW-1:0];
        rd_addr = rd_ptr[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            wr_ptr <= wr_ptr + wr_step;
            if (rt_en)
                rd_ptr <= '0;
            else
                rd_ptr <= rd_ptr + rd_step;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |=> wr_ptr == $past(wr_ptr)); // R3

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !rt_en) |=> rd_ptr == $past(rd_ptr)); // R4

    AST_RT_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        rt_en |=> (rd_ptr == '0) && (wr_ptr == $past(wr_ptr))); // R8

endmodule

// File: rtl/rf_store.sv
module rf_store #(
    parameter int DW    = 9,
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_acc,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_acc,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_acc)
            mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_acc;
            if (rd_acc)
                rd_data <= mem[rd_addr];
        end
    end

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(rd_data)); // R11

endmodule

// File: rtl/rf_occ_fsm.sv
module rf_occ_fsm
    import replay_fifo_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int PW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_acc,
    input  logic          rd_acc,
    input  logic          rewind,
    input  logic [PW-1:0] cnt_next,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);

    localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

    occ_e state;
    occ_e state_nxt;
    logic grow;
    logic shrink;

    function automatic occ_e level_of(input logic [PW-1:0] c);
        if (c == '0)
            return OCC_EMPTY;
        else if (c == FULL_CNT)
            return OCC_FULL;
        else if (c > HALF_CNT)
            return OCC_HIGH;
        else
            return OCC_LOW;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= OCC_EMPTY;
        else
            state <= state_nxt;
    end

    always_comb begin
        grow      = wr_acc && !rd_acc;
        shrink    = rd_acc && !wr_acc;
        state_nxt = state;
        unique case (state)
            OCC_EMPTY: begin
                if (rewind)
                    state_nxt = level_of(cnt_next);      // REWIND
                else if (grow)
                    state_nxt = (cnt_next > HALF_CNT) ? OCC_HIGH : OCC_LOW; // FILL
            end
            OCC_LOW: begin
                if (rewind)
                    state_nxt = level_of(cnt_next);      // REWIND
                else if (grow && cnt_next > HALF_CNT)
                    state_nxt = OCC_HIGH;                // CROSS_UP
                else if (shrink && cnt_next == '0)
                    state_nxt = OCC_EMPTY;               // DRAIN
            end
            OCC_HIGH: begin
                if (rewind)
                    state_nxt = level_of(cnt_next);      // REWIND
                else if (grow && cnt_next == FULL_CNT)
                    state_nxt = OCC_FULL;                // TOP
                else if (shrink && cnt_next <= HALF_CNT)
                    state_nxt = OCC_LOW;                 // CROSS_DOWN
            end
            OCC_FULL: begin
                if (rewind)
                    state_nxt = level_of(cnt_next);      // REWIND
                else if (shrink)
                    state_nxt = (cnt_next > HALF_CNT) ? OCC_HIGH : OCC_LOW; // LEAVE_TOP
            end
            default: state_nxt = OCC_EMPTY;
        endcase
    end

    always_comb begin
        empty_n = (state != OCC_EMPTY);
        full_n  = (state != OCC_FULL);
        half_n  = !((state == OCC_HIGH) || (state == OCC_FULL));
    end

    AST_HALF_SET_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(half_n) |-> ($past(wr_acc) || $past(rewind))); // R7

    AST_HALF_CLR_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_n) |-> ($past(rd_acc) || $past(rewind))); // R7

    AST_EMPTY_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty_n) |-> ($past(wr_acc) || $past(rewind))); // R5

    AST_FULL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_n) |-> ($past(wr_acc) || $past(rewind))); // R6

endmodule

// File: rtl/replay_fifo.sv
module replay_fifo #(
    parameter int DW    = 9,
    parameter int DEPTH = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          rt_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          wr_acc;
    logic          rd_acc;
    logic          rewind;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic [PW-1:0] cnt_next;

    rf_ptr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) i_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .rt_en    (rt_en),
        .empty_n  (empty_n),
        .full_n   (full_n),
        .wr_acc   (wr_acc),
        .rd_acc   (rd_acc),
        .rewind   (rewind),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .cnt_next (cnt_next)
    );

    rf_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_acc   (wr_acc),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_acc   (rd_acc),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    rf_occ_fsm #(.DEPTH(DEPTH), .PW(PW)) i_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_acc   (wr_acc),
        .rd_acc   (rd_acc),
        .rewind   (rewind),
        .cnt_next (cnt_next),
        .empty_n  (empty_n),
        .full_n   (full_n),
        .half_n   (half_n)
    );

    AST_RT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        rt_en |=> !rd_valid); // R9

    AST_RDV_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_en) && $past(empty_n) && !$past(rt_en))); // R11

    AST_FLAG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> (!half_n && empty_n)); // R6

endmodule

// File: tb/test_replay_fifo.sv
module test_replay_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int BD         = 8;
    localparam int BH         = BD / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       rt_en = 1'b0;
    logic [8:0] rd_data;
    logic       rd_valid;
    logic       empty_n;
    logic       full_n;
    logic       half_n;

    int checks = 0;
    int failures = 0;

    // Requirement-level model state
    logic [8:0] mdl [BD];
    int         wp = 0;
    int         rp = 0;
    logic [8:0] exp_rd = '0;
    logic       exp_rv = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    replay_fifo #(.DW(9), .DEPTH(BD)) i_replay_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rt_en    (rt_en),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .empty_n  (empty_n),
        .full_n   (full_n),
        .half_n   (half_n)
    );

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual={e,f,h,v,data}=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        int cnt;
        logic [12:0] e;
        cnt = wp - rp;
        e = {cnt != 0, cnt != BD, !(cnt > BH), exp_rv, exp_rd};
        check(tag, {empty_n, full_n, half_n, rd_valid, rd_data}, e);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0; rt_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        wp = 0; rp = 0; exp_rd = '0; exp_rv = 1'b0;
        @(negedge clk);
    endtask

    // One strobe cycle: drive at a falling edge, judge at the next falling edge.
    task automatic step(input string tag, input logic w, input logic [8:0] d,
                        input logic r, input logic rt);
        bit wa;
        bit ra;
        wr_en = w; wr_data = d; rd_en = r; rt_en = rt;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; rt_en = 1'b0;
        if (rt) begin
            rp = 0;
            exp_rv = 1'b0;
        end else begin
            wa = w && ((wp - rp) != BD);
            ra = r && ((wp - rp) != 0);
            if (ra) begin
                exp_rd = mdl[rp % BD];
                rp++;
            end
            if (wa) begin
                mdl[wp % BD] = d;
                wp++;
            end
            exp_rv = ra;
        end
        check_outputs(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired before the test ended");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1", {empty_n, full_n, half_n, rd_valid, rd_data}, 13'b0_1_1_0_000000000);

        // R5 R6 R7: fill to full, flags checked on every write
        for (int i = 0; i < BD; i++)
            step((i == BD-1) ? "R6" : ((i >= BH) ? "R7" : "R5"),
                 1'b1, 9'(9'h100 | (i * 9'd29)), 1'b0, 1'b0);
        // R3: write into full buffer dropped
        step("R3", 1'b1, 9'h1AA, 1'b0, 1'b0);
        // R2 R7 R5: drain, order and 9-bit data checked
        for (int i = 0; i < BD; i++)
            step((i == BD-1) ? "R5" : ((i >= BH-1) ? "R7" : "R2"),
                 1'b0, 9'h000, 1'b1, 1'b0);
        // R4: read from empty buffer dropped, data held
        step("R4", 1'b0, 9'h000, 1'b1, 1'b0);
        step("R4", 1'b0, 9'h000, 1'b1, 1'b0);

        // R10: simultaneous read and write at mid level and at full
        for (int i = 0; i < 3; i++) step("R10", 1'b1, 9'(9'h0F0 + i), 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step("R10", 1'b1, 9'(9'h1C0 + i), 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) step("R10", 1'b1, 9'(9'h050 + i), 1'b0, 1'b0);
        step("R10", 1'b1, 9'h155, 1'b1, 1'b0);
        step("R10", 1'b1, 9'h0AA, 1'b1, 1'b0);

        // R8: rewind after partial read, replay from first word
        do_reset();
        for (int i = 0; i < 5; i++) step("R8", 1'b1, 9'(9'h120 + i * 3), 1'b0, 1'b0);
        step("R8", 1'b0, 9'h000, 1'b1, 1'b0);
        step("R8", 1'b0, 9'h000, 1'b1, 1'b0);
        step("R8", 1'b0, 9'h000, 1'b0, 1'b1);
        for (int i = 0; i < 6; i++) step("R8", 1'b0, 9'h000, 1'b1, 1'b0);

        // R9: strobes arriving with rewind are ignored
        do_reset();
        for (int i = 0; i < 3; i++) step("R9", 1'b1, 9'(9'h0A1 + i), 1'b0, 1'b0);
        step("R9", 1'b0, 9'h000, 1'b1, 1'b0);
        step("R9", 1'b1, 9'h1FF, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) step("R9", 1'b0, 9'h000, 1'b1, 1'b0);

        // R11 R2 R10: mixed sweep over the 8-deep instance
        do_reset();
        for (int i = 0; i < 600; i++) begin
            int  ph;
            bit  w;
            bit  r;
            ph = (i / 40) % 4;
            w  = ((i * 5 + ph) % 7) < ((ph % 2 == 0) ? 5 : 2);
            r  = ((i * 3 + 1) % 7) < ((ph % 2 == 0) ? 2 : 5);
            step("R11", w, 9'((i * 37 + 11) % 512), r, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule